// File: doc/BRIEF.md
# Sectored Write Protection Controller

This block stands between the bus interface's write strobes and an 8K-byte memory array. It decides which writes reach the array. The space is split into eight 1K-byte sectors, and each sector has its own write-enable bit. The enable bits sit in a configuration register that only an explicit load changes; reset leaves it untouched, so it stands in for a nonvolatile setting. When software protection is switched on, a three-write unlock sequence must come before any data write. Writes that are not allowed are dropped silently.

Accepted bytes pass to the array one cycle after the request. The first accepted byte opens a page load. Later bytes join the load only if they fall in the same 32-byte page. After a fixed number of idle cycles the page load closes and an internal programming cycle of programmable length begins. It begins only while the external write-control input is high; while that input is low, a finished load waits. During programming every write is refused. Each read strobe inverts a polling bit, so software sees that bit toggle until programming ends. A single-byte write is simply a page load that holds one byte. When a programming cycle ends, the unlock sequence must be given again.

Top module: `wp_ctrl`

## Requirements
- R1: A write to address bits [12:10] = s is forwarded only when bit s of the sector-enable register is 1. A write to a disabled sector produces no array write and starts no page load.
- R2: The sector-enable register takes `cfg_val` on a cycle with `cfg_load` high. Reset does not change it.
- R3: While `sdp_on` is high, data writes are refused until three writes match these address/data pairs in order: (0x1555, 0xAA), (0x0AAA, 0x55), (0x1555, 0xA0). The key writes themselves are not forwarded. A write that does not match the next expected pair returns the tracker to its start.
- R4: When a programming cycle ends, the unlock tracker returns to its start, so further writes under `sdp_on` need a new sequence.
- R5: Once a page load is open, only writes whose address bits [12:5] match the first byte's are forwarded. Other writes are ignored.
- R6: An accepted write appears on `mem_we`, `mem_addr` and `mem_data` in the cycle after its request.
- R7: `busy` rises TIMEOUT+1 cycles after the last accepted byte's request edge, but only while `wc_allow` is high. While `wc_allow` is low, a finished load stays pending. It starts programming on the first edge at which `wc_allow` is high.
- R8: `busy` stays high for exactly PROG_CYC cycles, and no write is forwarded during it.
- R9: Each `rd_req` while `busy` is high inverts `poll`. `rd_req` while idle leaves `poll` unchanged.
- R10: After reset, `busy`, `poll` and `mem_we` are 0 and the unlock tracker is at its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sdp_on | input | 1 | Software protection enable |
| wc_allow | input | 1 | External permission for a page load to finish |
| cfg_load | input | 1 | Load strobe for the sector-enable register |
| cfg_val | input | 8 | New sector-enable bits, one per sector |
| wr_req | input | 1 | Write request strobe |
| wr_addr | input | 13 | Write address |
| wr_data | input | 8 | Write data |
| rd_req | input | 1 | Read strobe, used for status polling |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | 13 | Array write address |
| mem_data | output | 8 | Array write data |
| busy | output | 1 | Internal programming in progress |
| poll | output | 1 | Toggle-bit status |

## Verification
The sector gate is swept over every sector under several enable patterns: alternating, single-bit, all ones and all zeros. This separates a wrong bit index from an inverted or ignored enable. Unlock is tried in four ways: with no key, with the full key, with a key broken mid-way, and again after a programming cycle. These cases separate a tracker that never resets on a mismatch from one that forgets to relock. Writes are placed in the same page, in a neighbouring page, and during programming, to test the page grouping and the busy block. Timing of `busy` is measured cycle by cycle, with `wc_allow` held low and with it held high.

// File: rtl/wp_pkg.sv
package wp_pkg;
    localparam int ADDR_W   = 13;
    localparam int DATA_W   = 8;
    localparam int SEC_BITS = 3;
    localparam int SEC_N    = 1 << SEC_BITS;

    typedef enum logic [1:0] {UL_IDLE, UL_K1, UL_K2, UL_OPEN} ul_state_e;
    typedef enum logic [1:0] {PG_IDLE, PG_LOAD, PG_BUSY} pg_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_beat_t;

    function automatic logic [SEC_BITS-1:0] sector_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1 -: SEC_BITS];
    endfunction
endpackage

// File: rtl/wp_sector.sv
module wp_sector
    import wp_pkg::*;
#(
    parameter logic [SEC_N-1:0] CFG_INIT = '1
) (
    input  logic                clk,
    input  logic                cfg_load,
    input  logic [SEC_N-1:0]    cfg_val,
    input  logic [ADDR_W-1:0]   addr,
    output logic                sec_ok
);
    // Stand-in for a nonvolatile setting: no reset term.
    logic [SEC_N-1:0] en_q = CFG_INIT;

    always_ff @(posedge clk) begin
        if (cfg_load) en_q <= cfg_val;
    end

    assign sec_ok = en_q[sector_of(addr)];
endmodule

// File: rtl/wp_unlock.sv
module wp_unlock
    import wp_pkg::*;
#(
    parameter logic [ADDR_W-1:0] KA0 = 13'h1555,
    parameter logic [DATA_W-1:0] KD0 = 8'hAA,
    parameter logic [ADDR_W-1:0] KA1 = 13'h0AAA,
    parameter logic [DATA_W-1:0] KD1 = 8'h55,
    parameter logic [ADDR_W-1:0] KA2 = 13'h1555,
    parameter logic [DATA_W-1:0] KD2 = 8'hA0
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     sdp_on,
    input  logic     req,
    input  wr_beat_t beat,
    input  logic     relock,
    output logic     unlocked
);
    ul_state_e state;
    logic      key_hit;
    ul_state_e nxt;

    always_comb begin
        key_hit = 1'b0;
        nxt     = UL_IDLE;
        unique case (state)
            UL_IDLE: begin key_hit = (beat.addr == KA0) && (beat.data == KD0); nxt = UL_K1;   end
            UL_K1:   begin key_hit = (beat.addr == KA1) && (beat.data == KD1); nxt = UL_K2;   end
            UL_K2:   begin key_hit = (beat.addr == KA2) && (beat.data == KD2); nxt = UL_OPEN; end
            default: begin key_hit = 1'b0; nxt = UL_OPEN; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || relock || !sdp_on) state <= UL_IDLE;
        else if (req && state != UL_OPEN) state <= key_hit ? nxt : UL_IDLE;
    end

    assign unlocked = !sdp_on || (state == UL_OPEN);

    // R4: a finished programming cycle drops the tracker back to its start
    a_r4_relock: assert property (@(posedge clk) disable iff (rst)
        relock |=> state == UL_IDLE);
    // R3: a mismatching write while locked never advances the tracker
    a_r3_mismatch: assert property (@(posedge clk) disable iff (rst)
        (sdp_on && req && state != UL_OPEN && !key_hit && !relock) |=> state == UL_IDLE);
endmodule

// File: rtl/wp_page.sv
module wp_page
    import wp_pkg::*;
#(
    parameter int PAGE_BITS = 5,
    parameter int TIMEOUT   = 64,
    parameter int PROG_CYC  = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cand,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wc_allow,
    input  logic              rd_req,
    output logic              accept,
    output logic              busy,
    output logic              done,
    output logic              poll
);
    localparam int TAG_W = ADDR_W - PAGE_BITS;
    localparam int IW    = $clog2(TIMEOUT + 1);
    localparam int PW    = $clog2(PROG_CYC + 1);

    pg_state_e        state;
    logic [TAG_W-1:0] cur_tag;
    logic [IW-1:0]    idle_cnt;
    logic [PW-1:0]    prog_cnt;
    logic [TAG_W-1:0] req_tag;

    assign req_tag = addr[ADDR_W-1:PAGE_BITS];
    assign accept  = cand && ((state == PG_IDLE) ||
                              (state == PG_LOAD && req_tag == cur_tag));
    assign busy    = (state == PG_BUSY);
    assign done    = busy && (prog_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= PG_IDLE;
            cur_tag  <= '0;
            idle_cnt <= '0;
            prog_cnt <= '0;
            poll     <= 1'b0;
        end else begin
            unique case (state)
                PG_IDLE: if (accept) begin
                    state    <= PG_LOAD;
                    cur_tag  <= req_tag;
                    idle_cnt <= '0;
                end
                PG_LOAD: begin
                    if (accept) idle_cnt <= '0;
                    else if (idle_cnt == IW'(TIMEOUT)) begin
                        if (wc_allow) begin
                            state    <= PG_BUSY;
                            prog_cnt <= PW'(PROG_CYC - 1);
                        end
                    end else idle_cnt <= idle_cnt + 1'b1;
                end
                PG_BUSY: begin
                    if (rd_req) poll <= ~poll;
                    if (prog_cnt == '0) state <= PG_IDLE;
                    else prog_cnt <= prog_cnt - 1'b1;
                end
                default: state <= PG_IDLE;
            endcase
        end
    end

    // R7: a low write-control input keeps a finished load from programming
    a_r7_wc_hold: assert property (@(posedge clk) disable iff (rst)
        (state == PG_LOAD && !wc_allow) |=> state != PG_BUSY);
    // R9: each read during programming inverts the poll bit
    a_r9_toggle: assert property (@(posedge clk) disable iff (rst)
        (busy && rd_req) |=> poll != $past(poll));
    // R9: without a read during programming the poll bit holds
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !(busy && rd_req) |=> $stable(poll));
    // R5: an open load keeps its page tag until it closes
    a_r5_tag_stable: assert property (@(posedge clk) disable iff (rst)
        (state == PG_LOAD) |=> $stable(cur_tag));
endmodule

// File: rtl/wp_ctrl.sv
module wp_ctrl
    import wp_pkg::*;
#(
    parameter int               PAGE_BITS = 5,
    parameter int               TIMEOUT   = 64,
    parameter int               PROG_CYC  = 1000,
    parameter logic [SEC_N-1:0] CFG_INIT  = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sdp_on,
    input  logic              wc_allow,
    input  logic              cfg_load,
    input  logic [SEC_N-1:0]  cfg_val,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic              busy,
    output logic              poll
);
    wr_beat_t beat;
    logic     sec_ok, unlocked, accept, done, ul_req, cand;

    assign beat.addr = wr_addr;
    assign beat.data = wr_data;
    assign ul_req    = wr_req && !busy;
    assign cand      = ul_req && unlocked && sec_ok;

    wp_sector #(.CFG_INIT(CFG_INIT)) u_sector (
        .clk(clk), .cfg_load(cfg_load), .cfg_val(cfg_val),
        .addr(wr_addr), .sec_ok(sec_ok)
    );

    wp_unlock u_unlock (
        .clk(clk), .rst(rst), .sdp_on(sdp_on), .req(ul_req),
        .beat(beat), .relock(done), .unlocked(unlocked)
    );

    wp_page #(.PAGE_BITS(PAGE_BITS), .TIMEOUT(TIMEOUT), .PROG_CYC(PROG_CYC)) u_page (
        .clk(clk), .rst(rst), .cand(cand), .addr(wr_addr),
        .wc_allow(wc_allow), .rd_req(rd_req), .accept(accept),
        .busy(busy), .done(done), .poll(poll)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_we   <= 1'b0;
            mem_addr <= '0;
            mem_data <= '0;
        end else begin
            mem_we <= accept;
            if (accept) begin
                mem_addr <= beat.addr;
                mem_data <= beat.data;
            end
        end
    end

    // R1: a disabled sector never yields an array write
    a_r1_sector_gate: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !sec_ok) |=> !mem_we);
    // R3: nothing is forwarded while protection is on and the tracker is not open
    a_r3_locked: assert property (@(posedge clk) disable iff (rst)
        (wr_req && sdp_on && !unlocked) |=> !mem_we);
    // R8: writes during programming are refused
    a_r8_busy_block: assert property (@(posedge clk) disable iff (rst)
        (wr_req && busy) |=> !mem_we);
    // R6: a forwarded write carries the address requested one cycle earlier
    a_r6_addr: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_addr == $past(wr_addr));
endmodule

// File: tb/wp_ctrl_test.sv
module wp_ctrl_test;
    localparam int CLK_T = 10;
    localparam int TO    = 4;
    localparam int PC    = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sdp_on = 1'b0, wc_allow = 1'b1, cfg_load = 1'b0, wr_req = 1'b0, rd_req = 1'b0;
    logic [7:0]  cfg_val = '0, wr_data = '0;
    logic [12:0] wr_addr = '0;
    logic        mem_we, busy, poll;
    logic [12:0] mem_addr;
    logic [7:0]  mem_data;
    int          n_chk = 0, n_fail = 0;
    bit          finished = 0;

    always #(CLK_T/2) clk = ~clk;

    wp_ctrl #(.TIMEOUT(TO), .PROG_CYC(PC)) uut (
        .clk(clk), .rst(rst), .sdp_on(sdp_on), .wc_allow(wc_allow),
        .cfg_load(cfg_load), .cfg_val(cfg_val), .wr_req(wr_req),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_req(rd_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
        .busy(busy), .poll(poll)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic wr(input logic [12:0] a, input logic [7:0] d, input bit exp, input string req);
        wr_addr = a; wr_data = d; wr_req = 1'b1;
        @(negedge clk);
        wr_req = 1'b0;
        chk(mem_we == exp, req, mem_we, exp);
        if (exp && mem_we) begin
            chk(mem_addr == a, "R6 addr", mem_addr, a);
            chk(mem_data == d, "R6 data", mem_data, d);
        end
    endtask

    task automatic rd();
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic settle();
        tick(TO + PC + 3);
        chk(busy == 1'b0, "R8 idle after cycle", busy, 0);
    endtask

    task automatic load_cfg(input logic [7:0] v);
        cfg_val = v; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic key(input int broken);
        wr(13'h1555, 8'hAA, 1'b0, "R3 key1 not forwarded");
        if (broken == 1) wr(13'h0000, 8'h00, 1'b0, "R3 bad key");
        wr(13'h0AAA, 8'h55, 1'b0, "R3 key2 not forwarded");
        wr(13'h1555, 8'hA0, 1'b0, "R3 key3 not forwarded");
    endtask

    task automatic wrap_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            wrap_up();
        end
    end

    initial begin
        logic [7:0] pats [6];
        logic       p0;
        pats = '{8'hA5, 8'h5A, 8'h01, 8'h80, 8'hFF, 8'h00};
        tick(3);
        rst = 1'b0;
        tick(1);
        // R10: reset state
        chk(busy == 0, "R10 busy", busy, 0);
        chk(poll == 0, "R10 poll", poll, 0);
        chk(mem_we == 0, "R10 mem_we", mem_we, 0);

        // R1 / R2: sector sweep, with a reset after loading the first pattern
        foreach (pats[i]) begin
            load_cfg(pats[i]);
            if (i == 0) begin
                rst = 1'b1; tick(2); rst = 1'b0; tick(1);
            end
            for (int s = 0; s < 8; s++) begin
                logic [12:0] a;
                a = 13'((s << 10) | ((s * 37 + i) & 1023));
                wr(a, 8'(s ^ i), pats[i][s], i == 0 ? "R2 retained over reset" : "R1 sector gate");
                settle();
            end
        end

        // R7 / R8: exact busy timing and refusal during busy
        load_cfg(8'hFF);
        wr(13'h0100, 8'h3C, 1'b1, "R6 accept");
        tick(TO);
        chk(busy == 0, "R7 not before timeout", busy, 0);
        tick(1);
        chk(busy == 1, "R7 busy at timeout+1", busy, 1);
        wr(13'h0100, 8'h11, 1'b0, "R8 write during busy");
        tick(PC - 2);
        chk(busy == 1, "R8 busy last cycle", busy, 1);
        tick(1);
        chk(busy == 0, "R8 busy length", busy, 0);
        tick(2);

        // R5: page grouping
        wr(13'h0200, 8'h01, 1'b1, "R5 first byte");
        wr(13'h0201, 8'h02, 1'b1, "R5 same page");
        wr(13'h0220, 8'h03, 1'b0, "R5 other page ignored");
        wr(13'h021F, 8'h04, 1'b1, "R5 same page end");
        settle();

        // R7 hold and R9 toggle
        wc_allow = 1'b0;
        wr(13'h0300, 8'h55, 1'b1, "R7 accept");
        tick(TO + 10);
        chk(busy == 0, "R7 held by write-control", busy, 0);
        wc_allow = 1'b1;
        tick(1);
        chk(busy == 1, "R7 released", busy, 1);
        p0 = poll;
        rd();
        chk(poll == ~p0, "R9 first toggle", poll, ~p0);
        rd();
        chk(poll == p0, "R9 second toggle", poll, p0);
        settle();
        p0 = poll;
        rd();
        chk(poll == p0, "R9 idle read no toggle", poll, p0);

        // R3 / R4: software protection
        sdp_on = 1'b1;
        wr(13'h0400, 8'h77, 1'b0, "R3 locked data ignored");
        settle();
        key(0);
        wr(13'h0400, 8'h78, 1'b1, "R3 unlocked data");
        wr(13'h0401, 8'h79, 1'b1, "R3 unlocked page byte");
        settle();
        wr(13'h0402, 8'h7A, 1'b0, "R4 relocked after cycle");
        settle();
        key(1);
        wr(13'h0403, 8'h7B, 1'b0, "R3 broken key refused");
        settle();
        key(0);
        rst = 1'b1; tick(2); rst = 1'b0; tick(1);
        wr(13'h0404, 8'h7C, 1'b0, "R10 tracker reset");
        settle();
        key(0);
        wr(13'h0405, 8'h7D, 1'b1, "R3 reopened");
        settle();

        finished = 1;
        wrap_up();
    end
endmodule